// File: doc/BRIEF.md
# Dual-Role Serial Byte Port

This block moves one byte at a time over a four-wire serial bus (MOSI, MISO, SCK, SS). A mode bit in its control register chooses its role. As bus master it generates SCK from the system clock through a programmable divider. As a slave it follows an external SCK while its SS input is held low. Nothing happens until an enable bit is set. Software writes the control word, writes a byte into the data register and reads the result from the same register. A done flag shows when the eighth bit has been exchanged.

The block drives output-enable signals for all four pads. A pin register sets the default directions. Once the port is enabled, the chosen role overrides some of those directions: a master never drives MISO, and a slave never drives MOSI, SCK or SS. Transfers can be sent MSB first or LSB first, and all four clock polarity/phase modes are supported.

Register map (`reg_addr`): 0 = control, 1 = status, 2 = data, 3 = pins. Control bits are: bit0 enable, bit1 master, bit2 LSB-first, bit3 CPHA, bit4 CPOL, bits6:5 rate, bit7 double speed. Status bits are: bit0 done, bit1 busy. Pin register bits are: bit0 MOSI drive, bit1 MISO drive, bit2 SCK drive, bit3 SS drive, bit4 level driven on SS.

Top module: `spi_port`

## Requirements
- R1: After reset, control reads 0x00, pins reads 0x10, status reads 0x00, data reads 0x00, every output-enable is low and `ss_o` is high.
- R2: While enable (control bit0) is 0, a data write starts no transfer: SCK stays at its idle level, busy and done stay 0, and each pad output-enable equals its pin-register bit.
- R3: In enabled master mode, `miso_oe` is 0, and `mosi_oe`, `sck_oe` and `ss_oe` follow pin bits 0, 2 and 3.
- R4: In enabled slave mode, `mosi_oe`, `sck_oe` and `ss_oe` are 0. `miso_oe` equals pin bit1 while the synchronized SS is low, and it is 0 while SS is high.
- R5: With control bit2 = 0, bits leave and enter MSB first. With bit2 = 1, they go LSB first.
- R6: SCK idles at CPOL (bit4). With CPHA (bit3) = 0, data is sampled on the leading edge and changed on the trailing edge, and the first bit is valid before the first edge. With CPHA = 1, data is changed on the leading edge and sampled on the trailing edge.
- R7: In master mode, each SCK half-period lasts N/2 system clocks. N is 4, 16, 64 or 128 for rate 0..3 with double speed clear, and 2, 8, 32 or 64 with double speed set.
- R8: In master mode, a data write starts a 16-edge transfer. The done flag sets after the eighth bit and clears on the next data write. A data write made while busy is ignored.
- R9: After a transfer, the data register holds the byte received (MISO for a master, MOSI for a slave).
- R10: In slave mode, SS high clears the bit count. A partial transfer aborted by SS neither sets done nor skews the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| mosi_o | output | 1 | MOSI pad output |
| mosi_oe | output | 1 | MOSI pad drive enable |
| mosi_i | input | 1 | MOSI pad input |
| miso_o | output | 1 | MISO pad output |
| miso_oe | output | 1 | MISO pad drive enable |
| miso_i | input | 1 | MISO pad input |
| sck_o | output | 1 | SCK pad output |
| sck_oe | output | 1 | SCK pad drive enable |
| sck_i | input | 1 | SCK pad input |
| ss_o | output | 1 | SS pad output |
| ss_oe | output | 1 | SS pad drive enable |
| ss_i | input | 1 | SS pad input |

## Verification
The block has no parameters, so the bench builds it as it stands and reaches every configuration through the control register. This covers all eight divider settings, the four clock modes and both bit orders. In master runs, a bench-side slave model measures each SCK half-period. In slave runs, the bench drives SCK with a half-period long enough to cover the input synchronizers. A partial slave transfer aborted by SS exercises the bit-count reset.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       ss_o,
  output logic       ss_oe,
  input  logic       ss_i
);

  logic [7:0] ctrl, sh;
  logic [4:0] pins;
  logic       done, busy, ph, obit;
  logic [3:0] ecnt;
  logic [6:0] dcnt, half;
  logic [2:0] scnt;
  logic [2:0] sck_q;
  logic [1:0] ss_q, mosi_q;

  logic en, mst, lsbf, cpha, cpol, dbl;
  logic [1:0] rate;
  assign en   = ctrl[0];
  assign mst  = ctrl[1];
  assign lsbf = ctrl[2];
  assign cpha = ctrl[3];
  assign cpol = ctrl[4];
  assign rate = ctrl[6:5];
  assign dbl  = ctrl[7];

  always_comb begin
    case (rate)
      2'd0:    half = 7'd2;
      2'd1:    half = 7'd8;
      2'd2:    half = 7'd32;
      default: half = 7'd64;
    endcase
    if (dbl) half = half >> 1;
  end

  logic ss_s, top, din, data_wr;
  logic [7:0] shifted;
  assign ss_s    = ss_q[1];
  assign top     = lsbf ? sh[0] : sh[7];
  assign din     = mst ? miso_i : mosi_q[1];
  assign shifted = lsbf ? {din, sh[7:1]} : {sh[6:0], din};
  assign data_wr = reg_wr && (reg_addr == 2'd2);

  logic m_edge, m_sample;
  assign m_edge   = busy && (dcnt == half - 7'd1);
  assign m_sample = (ecnt[0] == cpha);

  logic s_rise, s_fall, s_lead, s_trail, s_sample, s_setup;
  assign s_rise   = sck_q[1] & ~sck_q[2];
  assign s_fall   = ~sck_q[1] & sck_q[2];
  assign s_lead   = cpol ? s_fall : s_rise;
  assign s_trail  = cpol ? s_rise : s_fall;
  assign s_sample = cpha ? s_trail : s_lead;
  assign s_setup  = cpha ? s_lead : s_trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= 8'h00;
      pins   <= 5'h10;
      sh     <= 8'h00;
      done   <= 1'b0;
      busy   <= 1'b0;
      ph     <= 1'b0;
      obit   <= 1'b0;
      ecnt   <= 4'd0;
      dcnt   <= 7'd0;
      scnt   <= 3'd0;
      sck_q  <= 3'b000;
      ss_q   <= 2'b11;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      ss_q   <= {ss_q[0], ss_i};
      mosi_q <= {mosi_q[0], mosi_i};
      if (reg_wr && reg_addr == 2'd0) ctrl <= reg_wdata;
      if (reg_wr && reg_addr == 2'd3) pins <= reg_wdata[4:0];
      if (data_wr && !busy) begin
        sh   <= reg_wdata;
        done <= 1'b0;
        obit <= lsbf ? reg_wdata[0] : reg_wdata[7];
        if (en && mst) begin
          busy <= 1'b1;
          ecnt <= 4'd0;
          dcnt <= 7'd0;
          ph   <= 1'b0;
        end
      end else if (en && mst) begin
        if (m_edge) begin
          dcnt <= 7'd0;
          ph   <= ~ph;
          ecnt <= ecnt + 4'd1;
          if (m_sample) sh <= shifted;
          else          obit <= top;
          if (ecnt == 4'd15) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else if (busy) begin
          dcnt <= dcnt + 7'd1;
        end
      end else if (en) begin
        if (ss_s) begin
          scnt <= 3'd0;
          obit <= top;
        end else if (s_sample) begin
          sh   <= shifted;
          scnt <= scnt + 3'd1;
          if (scnt == 3'd7) done <= 1'b1;
        end else if (s_setup) begin
          obit <= top;
        end
      end
      if (!en) begin
        busy <= 1'b0;
        ph   <= 1'b0;
        scnt <= 3'd0;
      end
    end
  end

  logic slave_en;
  assign slave_en = en & ~mst;

  assign mosi_o  = obit;
  assign miso_o  = obit;
  assign sck_o   = (en && mst) ? (cpol ^ ph) : cpol;
  assign ss_o    = pins[4];
  assign mosi_oe = pins[0] & ~slave_en;
  assign sck_oe  = pins[2] & ~slave_en;
  assign ss_oe   = pins[3] & ~slave_en;
  assign miso_oe = pins[1] & ~(en & mst) & ~(slave_en & ss_s);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl;
      2'd1:    reg_rdata = {6'd0, busy, done};
      2'd2:    reg_rdata = sh;
      default: reg_rdata = {3'd0, pins};
    endcase
  end

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic mst,
  input logic cpol,
  input logic busy,
  input logic done,
  input logic data_wr,
  input logic ss_s,
  input logic mosi_oe,
  input logic miso_oe,
  input logic sck_oe,
  input logic ss_oe,
  input logic sck_o
);

  AST_NO_BUSY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R2

  AST_MASTER_MISO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mst) |-> !miso_oe); // R3

  AST_SLAVE_PINS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mst) |-> (!mosi_oe && !sck_oe && !ss_oe)); // R4

  AST_SLAVE_MISO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mst && ss_s) |-> !miso_oe); // R4

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_o == cpol)); // R6

  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !busy) |=> !done); // R8

endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .cpol(cpol),
  .busy(busy), .done(done), .data_wr(data_wr), .ss_s(ss_s),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .sck_oe(sck_oe), .ss_oe(ss_oe),
  .sck_o(sck_o)
);

// File: tb/test_spi_port.sv
module test_spi_port;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic mosi_o, mosi_oe, mosi_i = 0, miso_o, miso_oe, miso_i = 0;
  logic sck_o, sck_oe, sck_i = 0, ss_o, ss_oe, ss_i = 1;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port i_spi_port (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic int exp_half(input logic [1:0] r, input logic d);
    int n;
    n = (r == 0) ? 4 : (r == 1) ? 16 : (r == 2) ? 64 : 128;
    if (d) n = n / 2;
    return n / 2;
  endfunction

  function automatic logic bitof(input logic [7:0] b, input int k, input logic lsbf);
    return lsbf ? b[k] : b[7-k];
  endfunction

  task automatic m_xfer(input logic [1:0] mode, input logic lsbf, input logic [1:0] rate,
                        input logic dbl, input logic [7:0] tx, input logic [7:0] sb);
    int h, iv, edges, smp, stp, bad, cyc, k;
    logic last;
    logic [7:0] cap, r;
    h = exp_half(rate, dbl);
    wr(0, {dbl, rate, mode[1], mode[0], lsbf, 1'b1, 1'b1});
    wr(3, 8'h0F);
    chk(!miso_oe && mosi_oe && sck_oe && ss_oe, "R3 master oe", {miso_oe, mosi_oe, sck_oe, ss_oe}, 4'b0111);
    chk(sck_o == mode[1], "R6 idle sck", sck_o, mode[1]);
    miso_i = bitof(sb, 0, lsbf);
    last = sck_o; cap = 0; edges = 0; smp = 0; stp = 0; bad = 0; iv = 0; cyc = 0;
    wr(2, tx);
    while (edges < 16 && cyc < 5000) begin
      @(negedge clk); iv++; cyc++;
      if (sck_o != last) begin
        last = sck_o;
        if (iv != h) bad++;
        iv = 0;
        if ((edges % 2) == int'(mode[0])) begin
          if (smp < 8) begin
            if (lsbf) cap[smp] = mosi_o; else cap[7-smp] = mosi_o;
          end
          smp++;
        end else begin
          k = stp + (mode[0] ? 0 : 1);
          if (k < 8) miso_i = bitof(sb, k, lsbf);
          stp++;
        end
        edges++;
      end
    end
    repeat (3) @(negedge clk);
    chk(bad == 0 && edges == 16, "R7 half period", bad, 0);
    chk(cap == tx, "R5/R6 mosi byte", cap, tx);
    chk(sck_o == mode[1], "R6 sck back idle", sck_o, mode[1]);
    rd(1, r); chk(r == 8'h01, "R8 done set", r, 8'h01);
    rd(2, r); chk(r == sb, "R9 received byte", r, sb);
  endtask

  task automatic s_xfer(input logic [1:0] mode, input logic lsbf,
                        input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] got, r;
    sck_i = mode[1]; ss_i = 1; mosi_i = 0;
    wr(0, {3'b000, mode[1], mode[0], lsbf, 1'b0, 1'b1});
    wr(3, 8'h0F);
    wr(2, sb);
    repeat (4) @(negedge clk);
    chk(!mosi_oe && !sck_oe && !ss_oe, "R4 slave inputs", {mosi_oe, sck_oe, ss_oe}, 0);
    chk(!miso_oe, "R4 miso off while ss high", miso_oe, 0);
    ss_i = 0;
    repeat (SH) @(negedge clk);
    chk(miso_oe, "R4 miso on while ss low", miso_oe, 1);
    got = 0;
    for (int k = 0; k < 8; k++) begin
      if (!mode[0]) begin
        mosi_i = bitof(mb, k, lsbf);
        repeat (SH) @(negedge clk);
        if (lsbf) got[k] = miso_o; else got[7-k] = miso_o;
        sck_i = ~sck_i;
        repeat (SH) @(negedge clk);
        sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i;
        mosi_i = bitof(mb, k, lsbf);
        repeat (SH) @(negedge clk);
        if (lsbf) got[k] = miso_o; else got[7-k] = miso_o;
        sck_i = ~sck_i;
        repeat (SH) @(negedge clk);
      end
      if (k == 4) begin
        rd(1, r); chk(r[0] == 0, "R10 no early done", r, 0);
      end
    end
    repeat (SH) @(negedge clk);
    ss_i = 1;
    repeat (4) @(negedge clk);
    chk(got == sb, "R5/R6 miso byte", got, sb);
    rd(1, r); chk(r[0] == 1, "R8 slave done", r, 1);
    rd(2, r); chk(r == mb, "R9 slave received", r, mb);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, r); chk(r == 8'h00, "R1 ctrl", r, 0);
    rd(3, r); chk(r == 8'h10, "R1 pins", r, 8'h10);
    rd(1, r); chk(r == 8'h00, "R1 status", r, 0);
    rd(2, r); chk(r == 8'h00, "R1 data", r, 0);
    chk({mosi_oe, miso_oe, sck_oe, ss_oe} == 0 && ss_o, "R1 pads", {mosi_oe, miso_oe, sck_oe, ss_oe, ss_o}, 1);

    // R2 disabled port
    wr(0, 8'h12); wr(3, 8'h0F); wr(2, 8'hA5);
    begin
      int moved = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk); if (sck_o != 1'b1) moved++;
      end
      chk(moved == 0, "R2 sck idle", moved, 0);
    end
    rd(1, r); chk(r == 8'h00, "R2 no busy/done", r, 0);
    rd(2, r); chk(r == 8'hA5, "R2 data loaded", r, 8'hA5);
    chk({mosi_oe, miso_oe, sck_oe, ss_oe} == 4'hF, "R2 oe follow pins", {mosi_oe, miso_oe, sck_oe, ss_oe}, 4'hF);

    for (int m = 0; m < 8; m++)
      m_xfer(m[1:0], m[2], 2'd0, 1'b1, 8'hC5 ^ 8'(m * 37), 8'h3A ^ 8'(m * 11));
    for (int d = 0; d < 8; d++)
      m_xfer(2'd0, 1'b0, d[1:0], d[2], 8'h96, 8'h69);

    // R8 write while busy ignored, done clears on next write
    wr(0, 8'h63); wr(3, 8'h0F); miso_i = 1;
    wr(2, 8'h00);
    repeat (100) @(negedge clk);
    wr(2, 8'h55);
    repeat (2000) @(negedge clk);
    rd(2, r); chk(r == 8'hFF, "R8 busy write ignored", r, 8'hFF);
    rd(1, r); chk(r == 8'h01, "R8 done after transfer", r, 1);
    wr(0, 8'h00);
    wr(2, 8'h12);
    rd(1, r); chk(r == 8'h00, "R8 done cleared by write", r, 0);

    for (int i = 0; i < 20; i++)
      m_xfer(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom));

    for (int m = 0; m < 8; m++)
      s_xfer(m[1:0], m[2], 8'($urandom), 8'($urandom));

    // R10 aborted partial slave transfer
    sck_i = 1'b0; wr(0, 8'h01); ss_i = 0;
    repeat (SH) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      mosi_i = 1; repeat (SH) @(negedge clk);
      sck_i = 1; repeat (SH) @(negedge clk); sck_i = 0;
    end
    repeat (SH) @(negedge clk);
    ss_i = 1;
    s_xfer(2'd0, 1'b0, 8'h5C, 8'hE1);

    for (int i = 0; i < 8; i++)
      s_xfer(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule